// File: doc/BRIEF.md
# Quasi-Bidirectional Port Shadow Controller

This block fronts a five-pin quasi-bidirectional port that is reached only through a byte-wide latch write and a byte-wide port read. Those transfers are carried out by a serial controller further down the chain. On a quasi-bidirectional port a pin becomes an input when a 1 is written to its latch bit, which lets the pin float high. Because of that, the block keeps three pieces of per-pin state:
- a direction flag, where an output flag marks the pin as driven;
- a requested-value shadow;
- the latch image itself.

From these it decides, for each command, whether a latch write or a port read is needed.

A host issues one command at a time. The four commands are set, toggle, get and set-direction. Set and toggle change the remembered value on every pin, but they reach the latch only for output pins, so an input is never pulled low by accident. A get on an output pin is answered from the latch image without any bus traffic. A get on an input pin starts a port read, and the answer is the bit at that pin's position. After reset the block configures every pin as an output, one pin at a time, before it accepts commands.

Top module: `qbgpio_shadow_ctrl`

## Requirements
- R1: A command whose pin index is 5 or more is answered in the next cycle with `rsp_err`=1 and `rsp_data`=0. It issues no bus request and leaves the value, direction and latch state unchanged.
- R2: A direction command (op 3) with `cmd_val`=1 makes the pin an input, and with `cmd_val`=0 makes it an output. The pin's latch bit becomes 1 for an input, and becomes the stored value for an output. A latch write always follows.
- R3: A set command (op 0) on an output pin stores `cmd_val`, copies it into the pin's latch bit and issues a latch write.
- R4: A set command on an input pin stores `cmd_val` only. The answer comes in the next cycle with no bus request and the latch bit unchanged. The stored value appears later, if the pin is switched to output.
- R5: A toggle command (op 1) always inverts the stored value. On an output pin it also inverts the latch bit and issues a latch write. On an input pin it issues no write.
- R6: A get command (op 2) on an output pin answers in the next cycle with `rsp_data` equal to the latch bit, and issues no bus request.
- R7: A get command on an input pin raises `rd_req`. The answer arrives in the cycle after `bus_done`, with `rsp_data` equal to `bus_rdata[pin]`.
- R8: After reset, the stored values and latch bits are 0 and all pins have cleared direction flags. The block then issues five latch writes, each of value 0x00, configuring pins 0 to 4 as outputs in ascending order. `cmd_ready` stays low until the fifth write is done.
- R9: Bits 7 to 5 of `wr_data` are 0 whenever `wr_req` is high. Bit i carries pin i's latch bit.
- R10: Only one command runs at a time. `wr_req` or `rd_req` stays high, with `wr_data` stable, until `bus_done`. `cmd_ready` is low while a command is in progress. `rsp_bus_err` returns the `bus_err` seen with `bus_done`, and is 0 for commands that used no bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 set, 1 toggle, 2 get, 3 direction |
| cmd_pin | input | 3 | Pin index |
| cmd_val | input | 1 | Value for set; for direction, 1 means input |
| cmd_ready | output | 1 | Block idle and accepting a command |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Pin index out of range |
| rsp_bus_err | output | 1 | Error status from the downstream transfer |
| rsp_data | output | 1 | Pin value returned by a get |
| wr_req | output | 1 | Latch write request, held until done |
| wr_data | output | 8 | Latch byte to write |
| rd_req | output | 1 | Port read request, held until done |
| bus_done | input | 1 | Downstream transfer finished |
| bus_err | input | 1 | Downstream transfer failed |
| bus_rdata | input | 8 | Byte read from the port |

## Verification
A command is accepted at a clock edge.

For a command that needs no bus transfer, `rsp_valid` is high in the very next cycle. This covers an index out of range, a set or toggle on an input pin, and a get on an output pin. For a command that does need a transfer, `wr_req` or `rd_req` is already high in that next cycle, with `wr_data` final. The response then follows exactly one cycle after the edge that sees `bus_done`.

The bench drives inputs on falling edges and samples on the next falling edge after the edge where each result is due. It holds `bus_done` back for a random 0 to 3 cycles and checks on each of those cycles that the request is still asserted.

// File: rtl/qbgpio_pkg.sv
package qbgpio_pkg;
    localparam int NPINS   = 5;
    localparam int LATCH_W = 8;
    localparam int PIN_W   = 3;
    localparam int PAD_W   = LATCH_W - NPINS;
    localparam int CTR_W   = $clog2(NPINS);

    typedef enum logic [1:0] {
        OP_SET    = 2'd0,
        OP_TOGGLE = 2'd1,
        OP_GET    = 2'd2,
        OP_DIR    = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [PIN_W-1:0] pin;
        logic             val;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_INIT_CFG,
        ST_INIT_WR,
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_RSP
    } state_e;

    typedef struct packed {
        logic bad_pin;
        logic need_wr;
        logic need_rd;
        logic out_bit;
    } plan_t;

    function automatic logic pin_in_range(logic [PIN_W-1:0] p);
        return int'(p) < NPINS;
    endfunction
endpackage

// File: rtl/qbgpio_shadow.sv
module qbgpio_shadow
    import qbgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic             apply,
    input  logic             init_apply,
    input  logic [CTR_W-1:0] init_pin,
    output plan_t            plan,
    output logic [NPINS-1:0] latch_q
);
    logic [NPINS-1:0] val_q;
    logic [NPINS-1:0] out_q;
    logic [PIN_W-1:0] idx;

    always_comb begin
        plan         = '0;
        plan.bad_pin = !pin_in_range(cmd.pin);
        idx          = plan.bad_pin ? '0 : cmd.pin;
        if (!plan.bad_pin) begin
            unique case (cmd.op)
                OP_SET, OP_TOGGLE: plan.need_wr = out_q[idx];
                OP_GET:            plan.need_rd = !out_q[idx];
                OP_DIR:            plan.need_wr = 1'b1;
                default:           plan.need_wr = 1'b0;
            endcase
            plan.out_bit = (cmd.op == OP_GET) && out_q[idx] && latch_q[idx];
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic hit;
        logic init_hit;
        assign hit      = apply && !plan.bad_pin && (int'(cmd.pin) == i);
        assign init_hit = init_apply && (int'(init_pin) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[i]   <= 1'b0;
                out_q[i]   <= 1'b0;
                latch_q[i] <= 1'b0;
            end else if (init_hit) begin
                out_q[i]   <= 1'b1;
                latch_q[i] <= val_q[i];
            end else if (hit) begin
                unique case (cmd.op)
                    OP_SET: begin
                        val_q[i] <= cmd.val;
                        if (out_q[i]) latch_q[i] <= cmd.val;
                    end
                    OP_TOGGLE: begin
                        val_q[i] <= !val_q[i];
                        if (out_q[i]) latch_q[i] <= !latch_q[i];
                    end
                    OP_DIR: begin
                        out_q[i]   <= !cmd.val;
                        latch_q[i] <= cmd.val | val_q[i];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/qbgpio_seq.sv
module qbgpio_seq
    import qbgpio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [PIN_W-1:0]   cmd_pin,
    input  plan_t              plan,
    input  logic               bus_done,
    input  logic               bus_err,
    input  logic [LATCH_W-1:0] bus_rdata,
    output logic               cmd_ready,
    output logic               accept,
    output logic               init_apply,
    output logic [CTR_W-1:0]   init_pin,
    output logic               wr_req,
    output logic               rd_req,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic               rsp_bus_err,
    output logic               rsp_data
);
    state_e             st;
    logic [CTR_W-1:0]   ctr;
    logic [PIN_W-1:0]   pin_q;

    assign cmd_ready  = (st == ST_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign init_apply = (st == ST_INIT_CFG);
    assign init_pin   = ctr;
    assign wr_req     = (st == ST_INIT_WR) || (st == ST_WR);
    assign rd_req     = (st == ST_RD);
    assign rsp_valid  = (st == ST_RSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_INIT_CFG;
            ctr         <= '0;
            pin_q       <= '0;
            rsp_err     <= 1'b0;
            rsp_bus_err <= 1'b0;
            rsp_data    <= 1'b0;
        end else begin
            unique case (st)
                ST_INIT_CFG: st <= ST_INIT_WR;
                ST_INIT_WR: if (bus_done) begin
                    if (int'(ctr) == NPINS - 1) begin
                        st <= ST_IDLE;
                    end else begin
                        ctr <= ctr + 1'b1;
                        st  <= ST_INIT_CFG;
                    end
                end
                ST_IDLE: if (accept) begin
                    pin_q       <= cmd_pin;
                    rsp_err     <= plan.bad_pin;
                    rsp_bus_err <= 1'b0;
                    rsp_data    <= plan.out_bit;
                    if (plan.need_wr)      st <= ST_WR;
                    else if (plan.need_rd) st <= ST_RD;
                    else                   st <= ST_RSP;
                end
                ST_WR: if (bus_done) begin
                    rsp_bus_err <= bus_err;
                    st          <= ST_RSP;
                end
                ST_RD: if (bus_done) begin
                    rsp_bus_err <= bus_err;
                    rsp_data    <= bus_rdata[pin_q];
                    st          <= ST_RSP;
                end
                ST_RSP:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qbgpio_shadow_ctrl.sv
module qbgpio_shadow_ctrl
    import qbgpio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [PIN_W-1:0]   cmd_pin,
    input  logic               cmd_val,
    output logic               cmd_ready,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic               rsp_bus_err,
    output logic               rsp_data,
    output logic               wr_req,
    output logic [LATCH_W-1:0] wr_data,
    output logic               rd_req,
    input  logic               bus_done,
    input  logic               bus_err,
    input  logic [LATCH_W-1:0] bus_rdata
);
    cmd_t             cmd;
    plan_t            plan;
    logic             accept;
    logic             init_apply;
    logic [CTR_W-1:0] init_pin;
    logic [NPINS-1:0] latch_q;

    assign cmd     = '{op: op_e'(cmd_op), pin: cmd_pin, val: cmd_val};
    assign wr_data = {{PAD_W{1'b0}}, latch_q};

    qbgpio_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .apply      (accept),
        .init_apply (init_apply),
        .init_pin   (init_pin),
        .plan       (plan),
        .latch_q    (latch_q)
    );

    qbgpio_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_pin     (cmd_pin),
        .plan        (plan),
        .bus_done    (bus_done),
        .bus_err     (bus_err),
        .bus_rdata   (bus_rdata),
        .cmd_ready   (cmd_ready),
        .accept      (accept),
        .init_apply  (init_apply),
        .init_pin    (init_pin),
        .wr_req      (wr_req),
        .rd_req      (rd_req),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_bus_err (rsp_bus_err),
        .rsp_data    (rsp_data)
    );
endmodule

// File: rtl/qbgpio_checker.sv
module qbgpio_checker
    import qbgpio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [PIN_W-1:0]   cmd_pin,
    input logic               wr_req,
    input logic               rd_req,
    input logic [LATCH_W-1:0] wr_data,
    input logic               bus_done,
    input logic               rsp_valid,
    input logic               rsp_err
);
    assert_bad_pin_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && int'(cmd_pin) >= NPINS)
        |=> (rsp_valid && rsp_err && !wr_req && !rd_req));

    assert_pad_zero_R9: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (wr_data[LATCH_W-1:NPINS] == '0));

    assert_single_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_req, rd_req, cmd_ready, rsp_valid}));

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !bus_done) |=> (wr_req && $stable(wr_data)));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !bus_done) |=> rd_req);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind qbgpio_shadow_ctrl qbgpio_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_pin   (cmd_pin),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .wr_data   (wr_data),
    .bus_done  (bus_done),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
);

// File: tb/tb_qbgpio_shadow_ctrl.sv
`timescale 1ns/1ps
module tb_qbgpio_shadow_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [2:0] cmd_pin = 3'd0;
    logic       cmd_val = 1'b0;
    logic       cmd_ready, rsp_valid, rsp_err, rsp_bus_err, rsp_data;
    logic       wr_req, rd_req;
    logic [7:0] wr_data;
    logic       bus_done = 1'b0;
    logic       bus_err = 1'b0;
    logic [7:0] bus_rdata = 8'd0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [4:0] m_val, m_out, m_latch;

    always #2 clk = ~clk;

    qbgpio_shadow_ctrl dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op, input int pin, input bit is_out);
        if (pin >= 5) return "R1";
        case (op)
            0: return is_out ? "R3" : "R4";
            1: return "R5";
            2: return is_out ? "R6" : "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic wait_ready();
        int guard = 0;
        while (!cmd_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(cmd_ready, "R10", "cmd_ready returns", int'(cmd_ready), 1);
    endtask

    task automatic run_cmd(input int op, input int pin, input bit v);
        bit    bad    = (pin >= 5);
        bit    is_out = bad ? 1'b0 : m_out[pin];
        bit    exp_wr = 0, exp_rd = 0, exp_data = 0, exp_berr = 0;
        string tg     = tag_of(op, pin, is_out);
        logic [7:0] rb;
        int    dly;
        wait_ready();
        if (!bad) begin
            case (op)
                0: begin m_val[pin] = v; if (is_out) begin m_latch[pin] = v; exp_wr = 1; end end
                1: begin m_val[pin] = ~m_val[pin];
                         if (is_out) begin m_latch[pin] = ~m_latch[pin]; exp_wr = 1; end end
                2: begin if (is_out) exp_data = m_latch[pin]; else exp_rd = 1; end
                default: begin m_out[pin] = ~v; m_latch[pin] = v | m_val[pin]; exp_wr = 1; end
            endcase
        end
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_pin = 3'(pin); cmd_val = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(wr_req == exp_wr, tg, "wr_req after accept", int'(wr_req), int'(exp_wr));
        chk(rd_req == exp_rd, tg, "rd_req after accept", int'(rd_req), int'(exp_rd));
        if (exp_wr)
            chk(wr_data == {3'b000, m_latch}, tg, "latch byte", int'(wr_data), int'({3'b000, m_latch}));
        if (exp_wr || exp_rd) begin
            dly = int'($urandom_range(3, 0));
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                chk(wr_req == exp_wr && rd_req == exp_rd && !rsp_valid, "R10", "request held",
                    int'({wr_req, rd_req}), int'({exp_wr, exp_rd}));
            end
            rb = 8'($urandom);
            exp_berr = ($urandom_range(3, 0) == 0);
            bus_rdata = rb; bus_err = exp_berr; bus_done = 1'b1;
            if (exp_rd) exp_data = rb[pin];
            @(negedge clk);
            bus_done = 1'b0; bus_err = 1'b0;
        end
        chk(rsp_valid, tg, "rsp_valid", int'(rsp_valid), 1);
        chk(rsp_err == bad, tg, "rsp_err", int'(rsp_err), int'(bad));
        chk(rsp_data == exp_data, tg, "rsp_data", int'(rsp_data), int'(exp_data));
        chk(rsp_bus_err == exp_berr, "R10", "rsp_bus_err", int'(rsp_bus_err), int'(exp_berr));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        m_val = '0; m_out = '0; m_latch = '0;
        repeat (3) @(negedge clk);
        chk(!cmd_ready && !wr_req && !rd_req && !rsp_valid, "R8", "reset state",
            int'({cmd_ready, wr_req, rd_req, rsp_valid}), 0);
        rst = 1'b0;
        // R8: five configuration writes of 0x00 before commands are taken
        for (int p = 0; p < 5; p++) begin
            int guard = 0;
            @(negedge clk);
            while (!wr_req && guard < 20) begin
                chk(!cmd_ready, "R8", "ready low during init", int'(cmd_ready), 0);
                @(negedge clk);
                guard++;
            end
            chk(wr_req && wr_data == 8'h00, "R8", "init write", int'(wr_data), 0);
            bus_done = 1'b1;
            @(negedge clk);
            bus_done = 1'b0;
            m_out[p] = 1'b1;
        end
        chk(cmd_ready, "R8", "ready after init", int'(cmd_ready), 1);

        // directed corner cases
        run_cmd(2, 0, 0);   // R6 get output, reads 0
        run_cmd(3, 2, 1);   // R2 to input: latch bit 2 = 1
        run_cmd(0, 2, 1);   // R4 set input: stored only
        run_cmd(0, 2, 0);   // R4 clear stored, latch stays 1
        run_cmd(1, 2, 0);   // R5 toggle input: stored becomes 1
        run_cmd(3, 2, 0);   // R2 back to output: latch = stored
        run_cmd(2, 2, 0);   // R6
        run_cmd(0, 4, 1);   // R3
        run_cmd(1, 4, 0);   // R5 toggle output
        run_cmd(3, 3, 1);   // R2
        run_cmd(2, 3, 0);   // R7 get input via port read
        run_cmd(0, 5, 1);   // R1
        run_cmd(3, 7, 1);   // R1
        run_cmd(2, 6, 0);   // R1
        run_cmd(2, 4, 0);   // R1 left state unchanged: R6 read back

        for (int n = 0; n < 300; n++)
            run_cmd(int'($urandom_range(3, 0)), int'($urandom_range(7, 0)), 1'($urandom));
        finish_run();
    end
endmodule